// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

The block waits for an edge on an external trigger line, then runs a 16-bit up-counter from zero and emits a single pulse. The pulse starts when the count reaches one programmed value and ends when it reaches a second. The trigger passes through a two-flop synchronizer. The edge that counts as a trigger can be rising, falling or either edge. The count advances once every 2^k clocks, with k taken from a 3-bit prescale select. The output's active level is programmable.

When the counter wraps past its maximum it parks at zero and raises an overflow flag. It stays parked until the next valid trigger. A trigger that arrives mid-count restarts the count and drops the output back to inactive. If the two compare values are equal, no pulse is produced.

Top module: `one_shot_pulse_timer`

## Requirements
- R1: Edge select `edge_sel_i` encodes 2'b01 = rising, 2'b10 = falling, 2'b11 = either edge, 2'b00 = no trigger. An input edge driven before clock edge n takes effect at clock edge n+2.
- R2: A valid trigger does all of the following, including while the counter is running: clears the count, clears the prescaler, starts counting, forces the output inactive and clears `ovf_o`.
- R3: While running and enabled, the count advances by one every 2^`presc_sel_i` clocks. t clocks after the trigger takes effect, the count equals floor(t / 2^k).
- R4: Take set < clear and P = 2^k, with t counted in clocks after the trigger takes effect. The output is active for set*P+1 <= t <= clear*P.
- R5: With set > clear, the output turns active at t = set*P+1 and stays active until the overflow.
- R6: When `cmp_set_i` equals `cmp_clr_i`, the output never becomes active.
- R7: With `act_high_i`=1 the active level of `pulse_o` is high and the inactive level is low. With `act_high_i`=0 both levels are inverted.
- R8: While `out_en_i` is 0, `pulse_o` is 0 whatever the internal state.
- R9: While `cnt_en_i` is 0, the count and the prescaler hold their values. A trigger still restarts the count from zero.
- R10: When the count advances from 16'hFFFF it goes to zero and stops. `ovf_o` is set and the output goes inactive. All of this holds until the next valid trigger.
- R11: After reset the counter is stopped, the output is inactive and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable |
| out_en_i | input | 1 | Output enable |
| trig_i | input | 1 | Asynchronous trigger input |
| edge_sel_i | input | 2 | Valid trigger edge select |
| presc_sel_i | input | 3 | Prescale exponent k; count every 2^k clocks |
| cmp_set_i | input | 16 | Count value that makes the output active |
| cmp_clr_i | input | 16 | Count value that makes the output inactive |
| act_high_i | input | 1 | 1: active level high; 0: active level low |
| pulse_o | output | 1 | Pulse output |
| ovf_o | output | 1 | Counter wrapped and is parked |

## Verification
The hardest state to reach from the ports is the parked state after a wrap. It needs a full pass of 65536 counts, and the pulse must still be active at the moment of the wrap. The bench reaches it with the prescaler at 1 and the set compare placed beyond the clear compare, so the pulse is still active when the count wraps. It then checks the exact clocks at which the output drops and `ovf_o` rises, and that a later trigger clears the flag. The second hard case is a restart in mid-pulse. The bench drives it by lowering the trigger and raising it again while the output is active. A sweep over every prescale value, small compare pairs and all three edge modes covers the timing formulas.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/otp_trig_sync.sv
module otp_trig_sync
  import otp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [1:0] edge_sel_i,
  output logic       vld_o
);
  // stages 0..SYNC_STAGES-1 synchronize, last stage holds history
  logic [SYNC_STAGES:0] sh_q;
  logic rise, fall;
  edge_sel_e mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], trig_i};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
  assign mode = edge_sel_e'(edge_sel_i);

  always_comb begin
    unique case (mode)
      EDGE_RISE: vld_o = rise;
      EDGE_FALL: vld_o = fall;
      EDGE_ANY:  vld_o = rise | fall;
      default:   vld_o = 1'b0;
    endcase
  end

  // R1: a rising-edge trigger cannot repeat on the next clock
  a_r1_rise_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && edge_sel_i == EDGE_RISE) |=> !(vld_o && edge_sel_i == EDGE_RISE));
endmodule

// File: rtl/otp_prescaler.sv
module otp_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q, mask;

  // 2^sel - 1; sel at its maximum wraps to all ones
  assign mask   = (PC_W'(1) << sel_i) - PC_W'(1);
  assign tick_o = en_i && ((pc_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (clr_i) pc_q <= '0;
    else if (en_i)  pc_q <= pc_q + PC_W'(1);
  end

  // R9: prescaler frozen while counting is disabled
  a_r9_presc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pc_q));
endmodule

// File: rtl/otp_core.sv
module otp_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_vld_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] cmp_set_i,
  input  logic [CNT_W-1:0] cmp_clr_i,
  output logic             run_o,
  output logic             act_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic run_q, act_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      act_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (trig_vld_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
      act_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (run_q) begin
      if (cmp_set_i == cmp_clr_i)  act_q <= 1'b0;
      else if (cnt_q == cmp_clr_i) act_q <= 1'b0;
      else if (cnt_q == cmp_set_i) act_q <= 1'b1;
      if (tick_i) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= '0;
          run_q <= 1'b0;
          ovf_q <= 1'b1;
          act_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign run_o = run_q;
  assign act_o = act_q;
  assign ovf_o = ovf_q;

  a_r2_trig_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_vld_i |=> (cnt_q == '0 && run_q && !act_q && !ovf_q));

  a_r10_ovf_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !trig_vld_i) |=> (ovf_q && !run_q && cnt_q == '0 && !act_q));

  a_r6_equal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_set_i == cmp_clr_i && !act_q) |=> !act_q);

  a_r3_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !trig_vld_i) |=> $stable(cnt_q));

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_q && !trig_vld_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/one_shot_pulse_timer.sv
module one_shot_pulse_timer #(
  parameter int CNT_W       = 16,
  parameter int PSEL_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_en_i,
  input  logic              out_en_i,
  input  logic              trig_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic [CNT_W-1:0]  cmp_set_i,
  input  logic [CNT_W-1:0]  cmp_clr_i,
  input  logic              act_high_i,
  output logic              pulse_o,
  output logic              ovf_o
);
  logic trig_vld, tick, run, act;

  otp_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (trig_i),
    .edge_sel_i (edge_sel_i),
    .vld_o      (trig_vld)
  );

  otp_prescaler #(.SEL_W(PSEL_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (trig_vld),
    .en_i   (run & cnt_en_i & ~trig_vld),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  otp_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_vld_i (trig_vld),
    .tick_i     (tick),
    .cmp_set_i  (cmp_set_i),
    .cmp_clr_i  (cmp_clr_i),
    .run_o      (run),
    .act_o      (act),
    .ovf_o      (ovf_o)
  );

  assign pulse_o = out_en_i & (act ^ ~act_high_i);
endmodule

// File: tb/tb_one_shot_pulse_timer.sv
module tb_one_shot_pulse_timer;
  localparam logic [1:0] M_OFF = 2'b00, M_RISE = 2'b01, M_FALL = 2'b10, M_ANY = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1, out_en = 1'b1, trig = 1'b0, act_high = 1'b1;
  logic [1:0]  edge_sel = M_OFF;
  logic [2:0]  psel = '0;
  logic [15:0] cmp_set = '0, cmp_clr = '0;
  logic        pulse, ovf;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  one_shot_pulse_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_en_i(cnt_en), .out_en_i(out_en),
    .trig_i(trig), .edge_sel_i(edge_sel), .presc_sel_i(psel),
    .cmp_set_i(cmp_set), .cmp_clr_i(cmp_clr), .act_high_i(act_high),
    .pulse_o(pulse), .ovf_o(ovf)
  );

  task automatic chk(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", what, got, exp);
    end
  endtask

  function automatic logic exp_act(int t, int s, int c, int p);
    if (s == c) return 1'b0;
    if (t < s * p + 1) return 1'b0;
    if (s < c) return (t <= c * p);
    return 1'b1;
  endfunction

  function automatic logic exp_pin(logic a, logic oe, logic ah);
    return oe ? (ah ? a : ~a) : 1'b0;
  endfunction

  // returns at the sample point t=0, one half clock after the trigger takes effect
  task automatic fire(input logic [1:0] mode);
    @(negedge clk);
    edge_sel = M_OFF;
    trig = (mode == M_FALL);
    repeat (4) @(negedge clk);
    edge_sel = mode;
    @(negedge clk);
    trig = ~trig;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic trial(input int k, input int s, input int c, input logic ah,
                       input logic oe, input logic [1:0] mode);
    int p, win;
    string rq;
    p = 1 << k;
    win = ((s > c ? s : c) + 2) * p;
    rq = (s < c) ? "R4" : (s > c) ? "R5" : "R6";
    psel = 3'(k); cmp_set = 16'(s); cmp_clr = 16'(c); act_high = ah; out_en = oe;
    fire(mode);
    for (int t = 0; t <= win; t++) begin
      chk(pulse, exp_pin(exp_act(t, s, c, p), oe, ah),
          $sformatf("%s/R3/R1/R7 k=%0d set=%0d clr=%0d mode=%0d t=%0d", rq, k, s, c, mode, t));
      chk(ovf, 1'b0, $sformatf("R10 no overflow k=%0d t=%0d", k, t));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pulse, 1'b0, "R11 pulse after reset");
    chk(ovf, 1'b0, "R11 ovf after reset");
    act_high = 1'b0;
    #1 chk(pulse, 1'b1, "R7 inactive level with active-low");
    act_high = 1'b1;

    // R1 edge select off: toggles ignored
    cmp_set = 16'd0; cmp_clr = 16'd5; psel = 3'd0;
    for (int i = 0; i < 4; i++) begin
      trig = ~trig;
      repeat (3) @(negedge clk);
      chk(pulse, 1'b0, $sformatf("R1 edge off toggle %0d", i));
    end
    trig = 1'b0;
    repeat (3) @(negedge clk);

    // sweep: prescale, compare pairs, edge modes, levels
    for (int k = 0; k < 8; k++)
      for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++)
          trial(k, s, c, logic'((s + k) % 2 == 0), logic'((s + c) != 5),
                2'((s + c + k) % 3 + 1));

    // R9 count enable low freezes the count
    act_high = 1'b1; out_en = 1'b1; psel = 3'd0; cmp_set = 16'd3; cmp_clr = 16'd6;
    cnt_en = 1'b0;
    fire(M_RISE);
    for (int t = 0; t < 10; t++) begin
      chk(pulse, 1'b0, $sformatf("R9 frozen t=%0d", t));
      @(negedge clk);
    end
    cnt_en = 1'b1;
    for (int u = 1; u <= 8; u++) begin
      @(negedge clk);
      chk(pulse, exp_act(u, 3, 6, 1), $sformatf("R9 resumed u=%0d", u));
    end

    // R2 retrigger mid-pulse
    cmp_set = 16'd2; cmp_clr = 16'd20;
    fire(M_RISE);
    repeat (8) @(negedge clk);
    chk(pulse, 1'b1, "R4 active at t=8 before restart");
    trig = 1'b0;
    repeat (3) @(negedge clk);
    chk(pulse, 1'b1, "R1 falling edge ignored in rising mode");
    trig = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int t = 0; t <= 5; t++) begin
      chk(pulse, exp_act(t, 2, 20, 1), $sformatf("R2 restart t=%0d", t));
      if (t == 5) begin
        out_en = 1'b0;
        #1 chk(pulse, 1'b0, "R8 output disabled while active");
        out_en = 1'b1;
        #1 chk(pulse, 1'b1, "R8 output re-enabled");
      end
      @(negedge clk);
    end

    // R10 overflow with pulse still active (R5)
    cmp_set = 16'd65530; cmp_clr = 16'd5;
    fire(M_RISE);
    for (int t = 0; t <= 65540; t++) begin
      if (t == 10 || t == 65530 || t == 65531 || t == 65535 || t == 65536 || t == 65540) begin
        chk(pulse, exp_act(t, 65530, 5, 1) && t < 65536, $sformatf("R5/R10 pulse t=%0d", t));
        chk(ovf, logic'(t >= 65536), $sformatf("R10 ovf t=%0d", t));
      end
      @(negedge clk);
    end
    fire(M_ANY);
    chk(ovf, 1'b0, "R2 trigger clears ovf");
    chk(pulse, 1'b0, "R2 inactive after trigger");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule